// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides, for every identifier that arrives on the receive path of a CAN controller, whether the frame is kept or dropped. It holds a build-time number of filter pairs. Each pair has a mask word and a reference identifier. An identifier passes a pair when it agrees with the reference in every bit position the mask marks as significant. Each pair has its own enable bit in a shared control word. An identifier is kept when any enabled pair passes it, and every identifier is kept while no pair is enabled.

Software programs the bank through a word-addressed register port. To retune a pair it first clears the pair's enable bit, then waits for the busy flag to read low, then writes the mask and afterwards the reference identifier, and finally sets the enable bit again. The mask and identifier of a pair cannot be changed while that pair is enabled. The busy flag covers two things: a comparison that is still in flight, and a short drain window after any enable bit is cleared. Once the flag is low, no decision in flight still depends on the old contents.

Each valid identifier takes two clock edges to produce a decision. The edge that samples `rx_valid` also captures the identifier and a snapshot of the enable bits. The following edge registers the decision on `rx_accept`, which is high for one cycle.

Top module: `can_accept_filter_bank`

## Requirements
- R1: After reset all enable bits, masks and reference identifiers are zero, and `rx_accept` and `busy` are low.
- R2: When `rx_valid` is high at edge E, `rx_accept` is high for exactly the cycle after edge E+1 if some pair that is enabled at E has a reference identifier equal to `rx_id` in every bit where its mask holds 1. Otherwise `rx_accept` stays low. `rx_accept` is never high without such a preceding `rx_valid`.
- R3: If no enable bit is set when `rx_valid` is sampled, that identifier is accepted whatever its value.
- R4: A disabled pair never causes acceptance while at least one other pair is enabled.
- R5: A write to the mask or identifier word of a pair whose enable bit is 1 leaves that word unchanged.
- R6: A write to the mask or identifier word of a disabled pair stores the low `ID_W` bits, and a read returns them.
- R7: In the cycle after an edge that samples `rx_valid` high, `busy` is 1.
- R8: A control write that clears any enable bit that was 1 raises `busy` for exactly `DRAIN` cycles after its edge. With no further traffic, `busy` then reads 0.
- R9: Register map, in word addresses. The control word is at 0, with bit k enabling pair k. The status word is at 1: bit 0 is `busy`, and writes to it have no effect. Pair k has its mask at 2+2k and its reference identifier at 3+2k. Addresses above 1+2N read as 0.
- R10: The enable bits used for a decision are those in force at the edge that samples `rx_valid`. A control write on that same edge does not affect that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | ID_W | Register write data |
| reg_rdata | output | ID_W | Register read data, combinational from `reg_addr` |
| rx_valid | input | 1 | Received identifier valid |
| rx_id | input | ID_W | Received identifier |
| rx_accept | output | 1 | One-cycle accept strobe |
| busy | output | 1 | Filter update or comparison in progress |

## Verification
A stale enable snapshot or a write that slips past the lock shows up as a wrong accept decision on the very next frame, two edges after its `rx_valid`. A read of the affected mask or identifier word exposes it one cycle after the offending write. A drain counter loaded with the wrong value shifts the falling edge of `busy`, and that is visible at the status port within `DRAIN` cycles of the clearing write. Random frames are biased toward identifiers that agree with a programmed pair in its significant bits, so that hits and misses both occur often.

// File: rtl/can_afb_pkg.sv
package can_afb_pkg;

  localparam int unsigned CTRL_WORD = 0;
  localparam int unsigned STAT_WORD = 1;

  // word address of the mask register of pair k
  function automatic int unsigned mask_word(input int unsigned k);
    return 32'd2 + 32'd2 * k;
  endfunction

  // word address of the reference identifier register of pair k
  function automatic int unsigned fid_word(input int unsigned k);
    return 32'd3 + 32'd2 * k;
  endfunction

  // significant bits of the received id agree with the reference
  function automatic logic id_hit(input logic [31:0] rx, input logic [31:0] mask,
                                  input logic [31:0] fid);
    return ((rx ^ fid) & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/afb_regs.sv
module afb_regs
  import can_afb_pkg::*;
#(
  parameter int N    = 4,
  parameter int ID_W = 29,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [ID_W-1:0] wdata,
  output logic [N-1:0]    en_q,
  output logic [ID_W-1:0] mask_q [N],
  output logic [ID_W-1:0] id_q   [N],
  output logic            clear_evt
);

  logic ctrl_sel;
  assign ctrl_sel  = we && (32'(addr) == CTRL_WORD);
  // an enable bit that is 1 now and written as 0
  assign clear_evt = ctrl_sel && |(en_q & ~wdata[N-1:0]);

  always_ff @(posedge clk) begin
    if (rst)           en_q <= '0;
    else if (ctrl_sel) en_q <= wdata[N-1:0];
  end

  for (genvar k = 0; k < N; k++) begin : g_pair
    logic msel, isel;
    assign msel = we && !en_q[k] && (32'(addr) == mask_word(k));
    assign isel = we && !en_q[k] && (32'(addr) == fid_word(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[k] <= '0;
        id_q[k]   <= '0;
      end else begin
        if (msel) mask_q[k] <= wdata;
        if (isel) id_q[k]   <= wdata;
      end
    end
  end

endmodule

// File: rtl/afb_match.sv
module afb_match
  import can_afb_pkg::*;
#(
  parameter int N    = 4,
  parameter int ID_W = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  input  logic [N-1:0]    en_q,
  input  logic [ID_W-1:0] mask_q [N],
  input  logic [ID_W-1:0] id_q   [N],
  output logic            stage_v,
  output logic            rx_accept
);

  logic [ID_W-1:0] stg_id;
  logic [N-1:0]    stg_en;
  logic [N-1:0]    hit;
  logic            accept_d;

  // stage 1: identifier and the enables in force at this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= 1'b0;
      stg_id  <= '0;
      stg_en  <= '0;
    end else begin
      stage_v <= rx_valid;
      if (rx_valid) begin
        stg_id <= rx_id;
        stg_en <= en_q;
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit[k] = stg_en[k] && id_hit(32'(stg_id), 32'(mask_q[k]), 32'(id_q[k]));
  end

  assign accept_d = stage_v && ((stg_en == '0) || (|hit));

  // stage 2: registered decision strobe
  always_ff @(posedge clk) begin
    if (rst) rx_accept <= 1'b0;
    else     rx_accept <= accept_d;
  end

endmodule

// File: rtl/afb_busy.sv
module afb_busy #(
  parameter int DRAIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_evt,
  input  logic stage_v,
  output logic busy
);

  localparam int CW = (DRAIN < 2) ? 1 : $clog2(DRAIN + 1);

  logic [CW-1:0] drain_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   drain_cnt <= '0;
    else if (clear_evt)        drain_cnt <= CW'(DRAIN);
    else if (drain_cnt != '0)  drain_cnt <= drain_cnt - 1'b1;
  end

  assign busy = stage_v || (drain_cnt != '0);

endmodule

// File: rtl/can_accept_filter_bank.sv
module can_accept_filter_bank
  import can_afb_pkg::*;
#(
  parameter int N     = 4,
  parameter int ID_W  = 29,
  parameter int AW    = 4,
  parameter int DRAIN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [ID_W-1:0] reg_wdata,
  output logic [ID_W-1:0] reg_rdata,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  output logic            rx_accept,
  output logic            busy
);

  logic [N-1:0]    en_q;
  logic [ID_W-1:0] mask_q [N];
  logic [ID_W-1:0] id_q   [N];
  logic            clear_evt;
  logic            stage_v;

  afb_regs #(.N(N), .ID_W(ID_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .mask_q(mask_q), .id_q(id_q), .clear_evt(clear_evt)
  );

  afb_match #(.N(N), .ID_W(ID_W)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id),
    .en_q(en_q), .mask_q(mask_q), .id_q(id_q),
    .stage_v(stage_v), .rx_accept(rx_accept)
  );

  afb_busy #(.DRAIN(DRAIN)) u_busy (
    .clk(clk), .rst(rst), .clear_evt(clear_evt), .stage_v(stage_v), .busy(busy)
  );

  always_comb begin
    reg_rdata = '0;
    if (32'(reg_addr) == CTRL_WORD) reg_rdata[N-1:0] = en_q;
    if (32'(reg_addr) == STAT_WORD) reg_rdata[0]     = busy;
    for (int unsigned k = 0; k < N; k++) begin
      if (32'(reg_addr) == mask_word(k)) reg_rdata = mask_q[k];
      if (32'(reg_addr) == fid_word(k))  reg_rdata = id_q[k];
    end
  end

endmodule

// File: rtl/afb_checker.sv
module afb_checker #(
  parameter int N     = 4,
  parameter int ID_W  = 29,
  parameter int AW    = 4,
  parameter int DRAIN = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_valid,
  input logic            rx_accept,
  input logic            busy,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [N-1:0]    ctl_bits,
  input logic [N-1:0]    en_q,
  input logic [ID_W-1:0] mask_q [N],
  input logic [ID_W-1:0] id_q   [N]
);

  localparam int QW = $clog2(DRAIN + 2) + 1;

  logic          clr_seen;
  logic [QW-1:0] quiet;

  assign clr_seen = reg_we && (reg_addr == '0) && |(en_q & ~ctl_bits);

  // cycles since the last frame or enable clear, saturating at DRAIN
  always_ff @(posedge clk) begin
    if (rst)                              quiet <= QW'(DRAIN);
    else if (rx_valid || clr_seen)        quiet <= '0;
    else if (32'(quiet) < 32'(DRAIN))     quiet <= quiet + 1'b1;
  end

  a_r2_accept_has_frame: assert property (@(posedge clk) disable iff (rst)
    rx_accept |-> $past(rx_valid, 2));

  a_r3_open_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && en_q == '0) |-> ##2 rx_accept);

  a_r7_busy_in_flight: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_valid)) |-> busy);

  a_r8_busy_on_clear: assert property (@(posedge clk) disable iff (rst)
    clr_seen |=> busy);

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    (32'(quiet) >= 32'(DRAIN)) |-> !busy);

  for (genvar k = 0; k < N; k++) begin : g_lock
    a_r5_locked_pair: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en_q[k])) |-> ($stable(mask_q[k]) && $stable(id_q[k])));
  end

endmodule

bind can_accept_filter_bank afb_checker #(
  .N(N), .ID_W(ID_W), .AW(AW), .DRAIN(DRAIN)
) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_accept(rx_accept), .busy(busy),
  .reg_we(reg_we), .reg_addr(reg_addr), .ctl_bits(reg_wdata[N-1:0]),
  .en_q(en_q), .mask_q(mask_q), .id_q(id_q)
);

// File: tb/can_accept_filter_bank_test.sv
`timescale 1ns/1ps
module can_accept_filter_bank_test;

  localparam int N = 4, IDW = 29, AW = 4, DRAIN = 3;
  localparam logic [IDW-1:0] ALL1 = '1;

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, rx_valid = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [IDW-1:0] wdata = '0, rx_id = '0, rdata;
  logic acc, busy;

  int errs = 0, chks = 0;
  logic [N-1:0]   m_en = '0;
  logic [IDW-1:0] m_mask [N];
  logic [IDW-1:0] m_id   [N];

  always #2.5 clk = ~clk;

  can_accept_filter_bank #(.N(N), .ID_W(IDW), .AW(AW), .DRAIN(DRAIN)) uut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .rx_valid(rx_valid), .rx_id(rx_id), .rx_accept(acc), .busy(busy)
  );

  function automatic int maddr(int k); return 2 + k * 2; endfunction
  function automatic int iaddr(int k); return maddr(k) + 1; endfunction

  function automatic logic model_acc(logic [IDW-1:0] id);
    if (m_en == '0) return 1'b1;
    for (int k = 0; k < N; k++)
      if (m_en[k] && ((id & m_mask[k]) == (m_id[k] & m_mask[k]))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [IDW-1:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (a == maddr(k) && !m_en[k]) m_mask[k] = d;
      if (a == iaddr(k) && !m_en[k]) m_id[k] = d;
    end
    if (a == 0) m_en = d[N-1:0];
  endtask

  task automatic rd(input int a, output logic [IDW-1:0] d);
    @(negedge clk); addr = AW'(a); #1; d = rdata;
  endtask

  task automatic send(input logic [IDW-1:0] id, input string tag);
    logic e;
    @(negedge clk); rx_valid = 1'b1; rx_id = id; e = model_acc(id);
    @(negedge clk); rx_valid = 1'b0;
    check("R7 busy while frame in flight", 32'(busy), 32'd1);
    @(negedge clk); check(tag, 32'(acc), 32'(e));
    @(negedge clk); check("R2 strobe lasts one cycle", 32'(acc), 32'd0);
  endtask

  task automatic prog(input int k, input logic [IDW-1:0] mk, input logic [IDW-1:0] id);
    logic [IDW-1:0] s;
    wr(0, IDW'(m_en & ~(N'(1) << k)));
    for (int i = 0; i < 50; i++) begin
      rd(1, s);
      if (s[0] == 1'b0) break;
    end
    check("R8 busy low before rewrite", 32'(s), 32'd0);
    wr(maddr(k), mk);
    wr(iaddr(k), id);
    wr(0, IDW'(m_en | (N'(1) << k)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [IDW-1:0] v;
    void'($urandom(32'd7));
    for (int k = 0; k < N; k++) begin m_mask[k] = '0; m_id[k] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 accept low", 32'(acc), 32'd0);
    check("R1 busy low", 32'(busy), 32'd0);
    rd(0, v);          check("R1 enables zero", 32'(v), 32'd0);
    rd(maddr(0), v);   check("R1 mask zero", 32'(v), 32'd0);
    rd(iaddr(N-1), v); check("R1 id zero", 32'(v), 32'd0);

    // R3 no pair enabled: everything accepted
    send(29'h0000_0000, "R3 open bank");
    send(29'h1ABC_DEF0, "R3 open bank");
    send(ALL1, "R3 open bank");

    // R6 / R9 programming and register map
    wr(maddr(0), 29'h0000_07FF); wr(iaddr(0), 29'h0000_0123);
    rd(maddr(0), v); check("R6 mask readback", 32'(v), 32'h7FF);
    rd(iaddr(0), v); check("R6 id readback", 32'(v), 32'h123);
    for (int a = 2 + 2 * N; a < 16; a++) begin
      rd(a, v); check("R9 unmapped reads zero", 32'(v), 32'd0);
    end
    wr(1, ALL1);
    rd(1, v); check("R9 status write ignored", 32'(v), 32'd0);
    rd(0, v); check("R9 status write leaves enables", 32'(v), 32'd0);

    // R2 single enabled pair
    wr(0, 29'd1);
    rd(0, v); check("R9 control readback", 32'(v), 32'd1);
    send(29'h0000_0123, "R2 exact hit");
    send(29'h0000_0124, "R2 miss");
    send(29'h1000_0123, "R2 bits outside mask ignored");

    // R4 disabled pair would match but is not used
    wr(maddr(1), ALL1); wr(iaddr(1), 29'h0000_0555);
    send(29'h0000_0555, "R4 disabled pair not used");

    // R5 writes to an enabled pair are dropped
    wr(maddr(0), 29'h0); wr(iaddr(0), 29'h0ABC);
    rd(maddr(0), v); check("R5 locked mask", 32'(v), 32'h7FF);
    rd(iaddr(0), v); check("R5 locked id", 32'(v), 32'h123);
    send(29'h0000_0ABC, "R5 locked pair still old");

    // R8 drain window after clearing an enable
    wr(0, 29'd0);
    for (int j = 0; j < DRAIN; j++) begin
      check("R8 busy during drain", 32'(busy), 32'd1);
      @(negedge clk);
    end
    check("R8 busy released", 32'(busy), 32'd0);

    // R10 enables snapshot on the frame edge
    wr(0, 29'd1);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = 29'h0000_0555; we = 1'b1; addr = '0; wdata = 29'd3;
    @(negedge clk); rx_valid = 1'b0; we = 1'b0; m_en = 4'd3;
    @(negedge clk); check("R10 decision uses old enables", 32'(acc), 32'd0);
    send(29'h0000_0555, "R10 new enables apply next frame");

    // constrained random mix
    for (int it = 0; it < 200; it++) begin
      int op, k;
      op = int'($urandom % 6);
      k  = int'($urandom % N);
      if (op == 0) begin
        logic [IDW-1:0] mk, id;
        mk = IDW'($urandom & $urandom); id = IDW'($urandom);
        prog(k, mk, id);
        rd(maddr(k), v); check("R6 random mask", 32'(v), 32'(m_mask[k]));
      end else if (op == 1) begin
        wr(0, IDW'($urandom % (1 << N)));
      end else if (op == 2) begin
        wr(($urandom % 2) ? maddr(k) : iaddr(k), IDW'($urandom));
        rd(maddr(k), v); check("R5 R6 mask after write", 32'(v), 32'(m_mask[k]));
        rd(iaddr(k), v); check("R5 R6 id after write", 32'(v), 32'(m_id[k]));
      end else begin
        logic [IDW-1:0] id;
        if (op >= 4) id = m_id[k] ^ (IDW'($urandom) & ~m_mask[k]);
        else         id = IDW'($urandom);
        send(id, "R2 R3 R4 random frame");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

endmodule